// File: doc/BRIEF.md
# Offset Cancel and Output Formatter

This block sits behind an analog-to-digital converter and cleans up its raw codes before they leave the converter's digital section. A self-calibration step is started by raising a calibration request. The block then asks the analog front end to tie its input to zero. The next conversion that arrives is kept as the converter's offset, and it is not passed on as a result.

After calibration, every incoming sample has the stored offset removed from it. The subtraction clamps at the most negative and most positive codes instead of wrapping. The corrected code is then presented in one of two number formats, picked per sample by a format select input. A format select of 0 gives two's complement. A format select of 1 gives offset binary, which is the same code with its top bit inverted.

Each result leaves through a single register stage and carries its own valid flag. The offset register starts at zero, so samples pass through unchanged until the first calibration.

Top module: `ofs_cancel_fmt`

## Requirements
- R1: After reset, `res_valid`, `cal_done` and `zero_force` are low and the stored offset is zero. A sample sent before any calibration comes out with its value unchanged when `fmt_bin` is 0.
- R2: A sample accepted with `raw_valid` high, while `zero_force` is low, produces `res_valid` high one clock later, together with its corrected and formatted `res_data`.
- R3: The correction is raw minus offset, with both read as signed two's complement values. A difference above 511 is output as 511 (10'h1FF). A difference below -512 is output as -512 (10'h200).
- R4: When `fmt_bin` is 0 in the sample's cycle, `res_data` is the corrected value in two's complement. When `fmt_bin` is 1, `res_data` is that value with bit 9 inverted.
- R5: A rising edge of `cal_req` while no calibration is running sets `zero_force` high from the next clock. `zero_force` stays high until a sample is captured.
- R6: The sample that arrives while `zero_force` is high is stored as the new offset, and no `res_valid` follows it. `cal_done` is high for exactly the one clock after the capture, and `zero_force` is low in that same clock.
- R7: The stored offset is applied to every later sample until a new calibration replaces it.
- R8: Holding `cal_req` high does not start another calibration. Only a new rising edge does.
- R9: `res_valid` is low in any clock that follows a clock in which `raw_valid` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_valid | input | 1 | Raw sample strobe |
| raw_data | input | 10 | Raw converter code, two's complement |
| cal_req | input | 1 | Calibration request, acts on its rising edge |
| fmt_bin | input | 1 | Output format select: 0 = two's complement, 1 = offset binary |
| res_valid | output | 1 | Result valid |
| res_data | output | 10 | Corrected, formatted result |
| cal_done | output | 1 | One-clock pulse once the offset is stored |
| zero_force | output | 1 | Request to the front end to hold its input at zero |

## Verification
Every result is due exactly one clock after its sample: `res_valid` and `res_data` appear together. `zero_force` rises one clock after the `cal_req` edge, and `cal_done` rises one clock after the captured sample. The bench drives its inputs on the falling clock edge and reads the outputs on the next falling edge, so each value is read half a period after the rising edge that registered it. The check on `cal_done` being a single-clock pulse, and the checks that no result appears after a capture or an idle clock, are made on the falling edge that follows.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    typedef enum logic [0:0] {
        CAL_IDLE = 1'b0,
        CAL_ARM  = 1'b1
    } cal_state_e;

endpackage

// File: rtl/ofs_cal_seq.sv
module ofs_cal_seq
    import ofs_pkg::*;
#(
    parameter int SAMPLE_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cal_req,
    input  logic                raw_valid,
    input  logic [SAMPLE_W-1:0] raw_data,
    output logic                zero_force,
    output logic                capture,
    output logic [SAMPLE_W-1:0] offset,
    output logic                cal_done
);

    typedef struct packed {
        cal_state_e          state;
        logic                req_prev;
        logic [SAMPLE_W-1:0] offset;
        logic                done;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.req_prev = cal_req;
        nxt_d.done     = 1'b0;
        capture        = 1'b0;
        unique case (cur_q.state)
            CAL_IDLE: begin
                if (cal_req && !cur_q.req_prev) begin
                    nxt_d.state = CAL_ARM;
                end
            end
            CAL_ARM: begin
                if (raw_valid) begin
                    capture      = 1'b1;
                    nxt_d.offset = raw_data;
                    nxt_d.done   = 1'b1;
                    nxt_d.state  = CAL_IDLE;
                end
            end
            default: nxt_d.state = CAL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{state: CAL_IDLE, req_prev: 1'b0, offset: '0, done: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign zero_force = (cur_q.state == CAL_ARM);
    assign offset     = cur_q.offset;
    assign cal_done   = cur_q.done;

    // R5: the zero request holds until a sample is captured
    p_zero_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_force && !raw_valid) |=> zero_force);

    // R6: the done pulse follows a capture and the zero request drops with it
    p_done_after_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (cal_done && !zero_force));

    // R6: the done pulse lasts one clock
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> !cal_done);

    // R8: a calibration only starts on a rising edge of the request
    p_edge_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_force && $past(cal_req) && $past(rst_n)) |=> !zero_force);

endmodule

// File: rtl/ofs_sat_sub.sv
module ofs_sat_sub #(
    parameter int SAMPLE_W = 10
) (
    input  logic [SAMPLE_W-1:0] minuend,
    input  logic [SAMPLE_W-1:0] subtrahend,
    output logic [SAMPLE_W-1:0] diff
);

    localparam int EXT_W = SAMPLE_W + 1;

    logic [EXT_W-1:0] wide;
    logic             ovf;

    always_comb begin
        wide = {minuend[SAMPLE_W-1], minuend} - {subtrahend[SAMPLE_W-1], subtrahend};
        ovf  = wide[EXT_W-1] ^ wide[SAMPLE_W-1];
        if (!ovf) begin
            diff = wide[SAMPLE_W-1:0];
        end else if (wide[EXT_W-1]) begin
            diff = {1'b1, {(SAMPLE_W-1){1'b0}}};
        end else begin
            diff = {1'b0, {(SAMPLE_W-1){1'b1}}};
        end
    end

endmodule

// File: rtl/ofs_fmt.sv
module ofs_fmt #(
    parameter int SAMPLE_W = 10
) (
    input  logic                to_bin,
    input  logic [SAMPLE_W-1:0] value,
    output logic [SAMPLE_W-1:0] coded
);

    always_comb begin
        coded             = value;
        coded[SAMPLE_W-1] = value[SAMPLE_W-1] ^ to_bin;
    end

endmodule

// File: rtl/ofs_cancel_fmt.sv
module ofs_cancel_fmt #(
    parameter int SAMPLE_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                raw_valid,
    input  logic [SAMPLE_W-1:0] raw_data,
    input  logic                cal_req,
    input  logic                fmt_bin,
    output logic                res_valid,
    output logic [SAMPLE_W-1:0] res_data,
    output logic                cal_done,
    output logic                zero_force
);

    typedef struct packed {
        logic                vld;
        logic [SAMPLE_W-1:0] data;
    } out_t;

    logic                capture;
    logic [SAMPLE_W-1:0] offset;
    logic [SAMPLE_W-1:0] corrected;
    logic [SAMPLE_W-1:0] coded;
    out_t                out_q, out_d;

    ofs_cal_seq #(.SAMPLE_W(SAMPLE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cal_req    (cal_req),
        .raw_valid  (raw_valid),
        .raw_data   (raw_data),
        .zero_force (zero_force),
        .capture    (capture),
        .offset     (offset),
        .cal_done   (cal_done)
    );

    ofs_sat_sub #(.SAMPLE_W(SAMPLE_W)) u_sub (
        .minuend    (raw_data),
        .subtrahend (offset),
        .diff       (corrected)
    );

    ofs_fmt #(.SAMPLE_W(SAMPLE_W)) u_fmt (
        .to_bin (fmt_bin),
        .value  (corrected),
        .coded  (coded)
    );

    always_comb begin
        out_d      = out_q;
        out_d.vld  = raw_valid && !capture;
        if (raw_valid && !capture) begin
            out_d.data = coded;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign res_valid = out_q.vld;
    assign res_data  = out_q.data;

    // R2: a normal sample yields a result one clock later
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_valid && !zero_force) |=> res_valid);

    // R6: the calibration sample is never output
    p_cal_hidden_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_valid && zero_force) |=> !res_valid);

    // R9: no result without a sample
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_valid |=> !res_valid);

endmodule

// File: tb/ofs_cancel_fmt_test.sv
`timescale 1ns/1ps
module ofs_cancel_fmt_test;

    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         raw_valid = 1'b0;
    logic [W-1:0] raw_data = '0;
    logic         cal_req = 1'b0;
    logic         fmt_bin = 1'b0;
    logic         res_valid;
    logic [W-1:0] res_data;
    logic         cal_done;
    logic         zero_force;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ofs_cancel_fmt #(.SAMPLE_W(W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_valid  (raw_valid),
        .raw_data   (raw_data),
        .cal_req    (cal_req),
        .fmt_bin    (fmt_bin),
        .res_valid  (res_valid),
        .res_data   (res_data),
        .cal_done   (cal_done),
        .zero_force (zero_force)
    );

    // vector: {fmt, raw[9:0], expected[9:0]}, offset +20 in force
    localparam int NV = 8;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 10'h064, 10'h050},  // R4 100-20=80
        {1'b1, 10'h064, 10'h250},  // R4 MSB inverted
        {1'b0, 10'h3FB, 10'h3E7},  // R7 -5-20=-25
        {1'b1, 10'h3FB, 10'h1E7},  // R4
        {1'b0, 10'h20C, 10'h200},  // R3 -520 clamps low
        {1'b1, 10'h20C, 10'h000},  // R3 R4
        {1'b0, 10'h1FF, 10'h1EB},  // R7 511-20=491
        {1'b1, 10'h014, 10'h200}   // R4 zero in offset binary
    };

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [W-1:0] v, input logic f, input logic [W-1:0] exp, input string req);
        @(negedge clk);
        raw_valid = 1'b1;
        raw_data  = v;
        fmt_bin   = f;
        @(negedge clk);
        raw_valid = 1'b0;
        check(W'(res_valid), W'(1), {req, " valid"});
        check(res_data, exp, req);
    endtask

    task automatic calibrate(input logic [W-1:0] v);
        @(negedge clk);
        cal_req = 1'b1;
        @(negedge clk);
        check(W'(zero_force), W'(1), "R5 zero_force rise");
        @(negedge clk);
        check(W'(zero_force), W'(1), "R5 zero_force hold");
        raw_valid = 1'b1;
        raw_data  = v;
        @(negedge clk);
        raw_valid = 1'b0;
        check(W'(res_valid), W'(0), "R6 no result for cal sample");
        check(W'(cal_done), W'(1), "R6 cal_done");
        check(W'(zero_force), W'(0), "R6 zero_force drop");
        @(negedge clk);
        check(W'(cal_done), W'(0), "R6 cal_done single");
        repeat (3) @(negedge clk);
        check(W'(zero_force), W'(0), "R8 held request no restart");
        cal_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(W'(res_valid), W'(0), "R1 res_valid reset");
        check(W'(cal_done), W'(0), "R1 cal_done reset");
        check(W'(zero_force), W'(0), "R1 zero_force reset");
        rst_n = 1'b1;
        send(10'h123, 1'b0, 10'h123, "R1 no offset before cal");
        send(10'h2AA, 1'b0, 10'h2AA, "R2 pass through");
        @(negedge clk);
        check(W'(res_valid), W'(0), "R9 idle no result");

        calibrate(10'h014);
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][19:10], VEC[i][20], VEC[i][9:0], "R3 R4 R7 vector");
        end

        // recalibrate with -30
        calibrate(10'h3E2);
        send(10'h1F4, 1'b0, 10'h1FF, "R3 clamp high");
        send(10'h1F4, 1'b1, 10'h3FF, "R3 R4 clamp high bin");
        send(10'h200, 1'b0, 10'h21E, "R7 new offset");

        // back-to-back samples
        @(negedge clk);
        raw_valid = 1'b1; raw_data = 10'h000; fmt_bin = 1'b0;
        @(negedge clk);
        check(res_data, 10'h01E, "R2 back-to-back first");
        raw_data = 10'h001;
        @(negedge clk);
        raw_valid = 1'b0;
        check(res_data, 10'h01F, "R2 back-to-back second");
        @(negedge clk);
        check(W'(res_valid), W'(0), "R9 after burst");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule